// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes one load request from a 32-lane warp and turns it into the shortest list of aligned memory transactions that covers every active lane. Each lane gives a byte address and reads one 4-byte word. An active mask marks which lanes take part. The coalescer gathers the active lanes that share a 128-byte region into one transaction. It then picks a segment size for that transaction and issues the transactions one at a time.

Requests enter on a valid/ready port. The port accepts a request only while the block is idle. Transactions leave on a second valid/ready port. Back-pressure is plain: while `txn_valid` is high and `txn_ready` is low, the offered transaction and all of its fields stay frozen. A transaction counts as issued on a clock edge where both `txn_valid` and `txn_ready` are high. After the last transaction is issued, a one-cycle `done` pulse reports how many transactions were issued. The next request can be accepted on the cycle after that pulse.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high while idle and low from the cycle after a request is accepted through the cycle of its `done` pulse. It is high again on the cycle after `done`.
- R2: Lanes whose mask bit is clear produce no transaction and never appear in `txn_lanes`. A request with an all-zero mask gives `done` on the cycle after acceptance, with `done_count` equal to 0.
- R3: `txn_size` uses the codes 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes. `txn_base` is a multiple of the size it carries.
- R4: One transaction serves every active lane whose address lies in the same aligned 128-byte region. If those lanes touch more than one 32-byte sector, the transaction is 128 bytes at the region base. Otherwise it is 32 bytes at the base of that sector.
- R5: Every active lane is served by exactly one transaction. Examples: a contiguous warp with a 128-byte-aligned base gives one 128-byte transaction. The same pattern shifted off alignment gives two. A stride of 2 words gives two 128-byte transactions. A stride of 32 words gives 32 transactions of 32 bytes.
- R6: Transactions are issued in ascending order of the lowest lane that each one serves.
- R7: At most one transaction is issued per cycle. A stalled transaction holds `txn_valid`, `txn_base`, `txn_size` and `txn_lanes` unchanged until it is taken.
- R8: `done` is high for exactly one cycle, the cycle after the final transaction is issued, and `done_count` then equals the number of transactions issued.
- R9: For a request with a non-zero mask, the first transaction is offered on the cycle after acceptance. Each following transaction is offered on the cycle after the previous one is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | The block is idle and takes the offered request |
| req_addr | input | LANES*ADDR_W | Lane byte addresses; lane k occupies bits [k*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active lanes; bit k is lane k |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | The downstream port takes the transaction |
| txn_base | output | ADDR_W | Segment base byte address |
| txn_size | output | 2 | Segment size code (0 = 32 B, 1 = 64 B, 2 = 128 B) |
| txn_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse after the last transaction |
| done_count | output | $clog2(LANES+1) | Number of transactions issued for the request |

## Verification
A request accepted on edge T offers its first transaction on the cycle after T. A request with an empty mask instead raises `done` on that cycle. Each later transaction appears on the cycle after the previous handshake, and `done` follows one cycle after the final handshake. The bench drives inputs on falling edges and samples outputs on the next falling edge. For each cycle it works out which of these results is due, and it flags a missing transaction or a missing `done` in exactly that cycle. Random `txn_ready` stalls check that a transaction stays frozen, cycle by cycle, while it waits.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int unsigned SECTOR_BYTES = 32;
  localparam int unsigned REGION_BYTES = 128;
  localparam int unsigned SEC_LSB      = $clog2(SECTOR_BYTES);
  localparam int unsigned REG_LSB      = $clog2(REGION_BYTES);
  localparam int unsigned SEC_SEL_W    = REG_LSB - SEC_LSB;
  localparam int unsigned SECTORS      = REGION_BYTES / SECTOR_BYTES;

  typedef enum logic [1:0] {
    SEG_32  = 2'd0,
    SEG_64  = 2'd1,
    SEG_128 = 2'd2
  } seg_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;
endpackage

// File: rtl/coal_lane_pick.sv
module coal_lane_pick #(
  parameter int unsigned LANES  = 32,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]  pending,
  output logic              any,
  output logic [LANE_W-1:0] lead
);
  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) lead = LANE_W'(i);
    end
  end
  assign any = |pending;
endmodule

// File: rtl/coal_group.sv
module coal_group #(
  parameter int unsigned LANES = 32,
  parameter int unsigned SEG_W = 27,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [LANES*SEG_W-1:0]          seg_addr,
  input  logic [LANES-1:0]                pending,
  input  logic [LANE_W-1:0]               lead,
  output logic [SEG_W-1:0]                lead_seg,
  output logic [LANES-1:0]                match,
  output logic [coal_pkg::SECTORS-1:0]    touched
);
  import coal_pkg::*;
  localparam int unsigned RGN_W = SEG_W - SEC_SEL_W;

  assign lead_seg = seg_addr[lead*SEG_W +: SEG_W];

  logic [SECTORS-1:0] lane_sec [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SEG_W-1:0] a;
    assign a        = seg_addr[k*SEG_W +: SEG_W];
    assign match[k] = pending[k] &&
                      (a[SEG_W-1:SEC_SEL_W] == lead_seg[SEG_W-1:SEC_SEL_W]);
    always_comb begin
      lane_sec[k] = '0;
      if (match[k]) lane_sec[k][a[SEC_SEL_W-1:0]] = 1'b1;
    end
  end

  always_comb begin
    touched = '0;
    for (int k = 0; k < LANES; k++) touched = touched | lane_sec[k];
  end

  logic [RGN_W-1:0] unused_rgn;
  assign unused_rgn = '0;
endmodule

// File: rtl/coal_segment.sv
module coal_segment #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEG_W  = 27
) (
  input  logic [SEG_W-1:0]             lead_seg,
  input  logic [coal_pkg::SECTORS-1:0] touched,
  output logic [ADDR_W-1:0]            base,
  output coal_pkg::seg_size_e          size
);
  import coal_pkg::*;
  logic wide;
  assign wide = ($countones(touched) > 1);

  always_comb begin
    if (wide) begin
      size = SEG_128;
      base = {lead_seg[SEG_W-1:SEC_SEL_W], {REG_LSB{1'b0}}};
    end else begin
      size = SEG_32;
      base = {lead_seg, {SEC_LSB{1'b0}}};
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_mask,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_base,
  output logic [1:0]              txn_size,
  output logic [LANES-1:0]        txn_lanes,
  output logic                    done,
  output logic [CNT_W-1:0]        done_count
);
  import coal_pkg::*;
  localparam int unsigned SEG_W  = ADDR_W - SEC_LSB;
  localparam int unsigned LANE_W = $clog2(LANES);

  coal_state_e              state_q;
  logic [LANES*SEG_W-1:0]   seg_q;
  logic [LANES-1:0]         pend_q;
  logic [CNT_W-1:0]         cnt_q;

  logic [LANES*SEG_W-1:0]   seg_in;
  logic [LANES*SEC_LSB-1:0] unused_low;
  for (genvar k = 0; k < LANES; k++) begin : g_split
    assign seg_in[k*SEG_W +: SEG_W] = req_addr[k*ADDR_W + SEC_LSB +: SEG_W];
    assign unused_low[k*SEC_LSB +: SEC_LSB] = req_addr[k*ADDR_W +: SEC_LSB];
  end

  logic               any;
  logic [LANE_W-1:0]  lead;
  logic [SEG_W-1:0]   lead_seg;
  logic [LANES-1:0]   match;
  logic [SECTORS-1:0] touched;
  seg_size_e          size;

  coal_lane_pick #(.LANES(LANES)) u_pick (
    .pending(pend_q), .any(any), .lead(lead)
  );

  coal_group #(.LANES(LANES), .SEG_W(SEG_W)) u_group (
    .seg_addr(seg_q), .pending(pend_q), .lead(lead),
    .lead_seg(lead_seg), .match(match), .touched(touched)
  );

  coal_segment #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_seg (
    .lead_seg(lead_seg), .touched(touched), .base(txn_base), .size(size)
  );

  logic busy, req_fire, txn_fire;
  assign busy      = (state_q == ST_BUSY);
  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;
  assign txn_valid = busy && any;
  assign txn_fire  = txn_valid && txn_ready;
  assign txn_lanes = match;
  assign txn_size  = size;
  assign done      = busy && !any;
  assign done_count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
      pend_q  <= '0;
      cnt_q   <= '0;
    end else if (req_fire) begin
      state_q <= ST_BUSY;
      seg_q   <= seg_in;
      pend_q  <= req_mask;
      cnt_q   <= '0;
    end else if (txn_fire) begin
      pend_q  <= pend_q & ~match;
      cnt_q   <= cnt_q + CNT_W'(1);
    end else if (done) begin
      state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/coal_check.sv
module coal_check #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_mask,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_base,
  input logic [1:0]        txn_size,
  input logic [LANES-1:0]  txn_lanes,
  input logic              done,
  input logic [CNT_W-1:0]  done_count
);
  logic [LANES-1:0] acc_mask, served;
  logic [CNT_W-1:0] fires;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_mask <= '0;
      served   <= '0;
      fires    <= '0;
    end else if (req_valid && req_ready) begin
      acc_mask <= req_mask;
      served   <= '0;
      fires    <= '0;
    end else if (txn_valid && txn_ready) begin
      served   <= served | txn_lanes;
      fires    <= fires + CNT_W'(1);
    end
  end

  p_busy_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_reopen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  p_active_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_lanes & ~acc_mask) == '0) && (txn_lanes != '0));
  p_align128_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_size == 2'd2) |-> (txn_base[6:0] == 7'd0));
  p_align32_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_size == 2'd0) |-> (txn_base[4:0] == 5'd0));
  p_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_lanes & served) == '0));
  p_all_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (served == acc_mask));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> txn_valid && $stable(txn_base)
      && $stable(txn_size) && $stable(txn_lanes));
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count == fires));
endmodule

bind warp_coalescer coal_check #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mask(req_mask), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .txn_base(txn_base), .txn_size(txn_size), .txn_lanes(txn_lanes),
  .done(done), .done_count(done_count)
);

// File: tb/sim_warp_coalescer.sv
`timescale 1ns/1ps
module sim_warp_coalescer;
  localparam int L = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [L*AW-1:0] req_addr = '0;
  logic [L-1:0] req_mask = '0;
  logic txn_valid;
  logic txn_ready = 1'b0;
  logic [AW-1:0] txn_base;
  logic [1:0] txn_size;
  logic [L-1:0] txn_lanes;
  logic done;
  logic [5:0] done_count;

  always #5 clk = ~clk;

  warp_coalescer #(.LANES(L), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_base(txn_base), .txn_size(txn_size),
    .txn_lanes(txn_lanes), .done(done), .done_count(done_count)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] a [L];
  logic [31:0] e_base [L];
  logic [1:0]  e_size [L];
  logic [L-1:0] e_lanes [L];
  int e_n;

  task automatic chk(input bit ok, input string req, input string msg,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  // Expected list from R4/R6: group pending active lanes by 128-byte region,
  // lowest remaining lane first; wide region -> 128 B, else 32 B sector.
  function automatic void model(input logic [L-1:0] m);
    logic [L-1:0] pend = m;
    e_n = 0;
    while (pend != '0) begin
      int ld = 0;
      logic [3:0] sec = '0;
      logic [L-1:0] grp = '0;
      for (int i = L - 1; i >= 0; i--) if (pend[i]) ld = i;
      for (int i = 0; i < L; i++)
        if (pend[i] && (a[i][31:7] == a[ld][31:7])) begin
          grp[i] = 1'b1;
          sec[a[i][6:5]] = 1'b1;
        end
      if ($countones(sec) > 1) begin
        e_size[e_n] = 2'd2; e_base[e_n] = {a[ld][31:7], 7'd0};
      end else begin
        e_size[e_n] = 2'd0; e_base[e_n] = {a[ld][31:5], 5'd0};
      end
      e_lanes[e_n] = grp;
      pend = pend & ~grp;
      e_n++;
    end
  endfunction

  task automatic run(input logic [L-1:0] m, input int stall_pct, input string tag);
    int idx = 0;
    bit want_done = 0;
    bit finished = 0;
    int guard = 0;
    model(m);
    for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = a[i];
    req_mask = m;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R9 / R2: first result due on this cycle
    if (e_n == 0) begin
      chk(done === 1'b1 && done_count == 0, "R2", {tag, " empty mask done"}, {63'd0, done}, 64'd1);
      finished = 1;
    end else begin
      chk(txn_valid === 1'b1, "R9", {tag, " first txn due"}, {63'd0, txn_valid}, 64'd1);
    end
    while (!finished && guard < 400) begin
      guard++;
      chk(req_ready === 1'b0, "R1", {tag, " closed while busy"}, {63'd0, req_ready}, 64'd0);
      if (want_done) begin
        chk(done === 1'b1 && txn_valid === 1'b0, "R8", {tag, " done after last"}, {63'd0, done}, 64'd1);
        chk(done_count == 6'(e_n), "R8", {tag, " count"}, 64'(done_count), 64'(e_n));
        finished = 1;
      end else begin
        chk(txn_valid === 1'b1 && done === 1'b0, "R9", {tag, " txn offered"}, {63'd0, txn_valid}, 64'd1);
        chk(txn_base == e_base[idx], "R4", {tag, " base"}, 64'(txn_base), 64'(e_base[idx]));
        chk(txn_size == e_size[idx], "R3", {tag, " size"}, 64'(txn_size), 64'(e_size[idx]));
        chk(txn_lanes == e_lanes[idx], "R6", {tag, " lanes/order"}, 64'(txn_lanes), 64'(e_lanes[idx]));
        txn_ready = ($urandom_range(99) >= stall_pct);
        @(negedge clk);
        if (txn_ready) begin
          idx++;
          if (idx == e_n) want_done = 1;
        end
        txn_ready = 1'b0;
        continue;
      end
      @(negedge clk);
    end
    if (!finished) chk(1'b0, "R8", {tag, " no done"}, 64'd0, 64'd1);
    if (e_n == 0) @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0, "R1", {tag, " reopens after done"}, {63'd0, req_ready}, 64'd1);
  endtask

  task automatic fill(input logic [31:0] base, input int stride_words);
    for (int i = 0; i < L; i++) a[i] = base + 32'(i * stride_words * 4);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0, "R1", "reset state",
        {61'd0, req_ready, txn_valid, done}, 64'h4);

    fill(32'h0000_1000, 1);  run('1, 0, "R5 aligned contiguous");
    chk(e_n == 1 && e_size[0] == 2'd2, "R5", "model one 128B", 64'(e_n), 64'd1);
    fill(32'h0000_1010, 1);  run('1, 30, "R5 misaligned");
    chk(e_n == 2, "R5", "model misaligned two", 64'(e_n), 64'd2);
    fill(32'h0000_2000, 2);  run('1, 0, "R5 stride2");
    chk(e_n == 2 && e_size[1] == 2'd2, "R5", "model stride2", 64'(e_n), 64'd2);
    fill(32'h0000_4000, 32); run('1, 20, "R5 stride32");
    chk(e_n == 32 && e_size[5] == 2'd0, "R5", "model stride32", 64'(e_n), 64'd32);
    fill(32'h0000_8000, 1);  run('0, 0, "R2 zero mask");
    fill(32'h0000_8000, 32); run(32'h8000_0001, 50, "R2 sparse mask");
    for (int i = 0; i < L; i++) a[i] = 32'h0000_9004;
    run('1, 0, "R4 broadcast one sector");
    chk(e_n == 1 && e_size[0] == 2'd0, "R4", "model broadcast 32B", 64'(e_n), 64'd1);
    for (int i = 0; i < L; i++) a[i] = 32'h0000_A000 + 32'((L - 1 - i) * 128);
    run('1, 40, "R6 reversed regions");

    for (int t = 0; t < 250; t++) begin
      int mode = $urandom_range(4);
      logic [31:0] b = {$urandom_range(32'h000F_FFFF), 2'b00} & 32'h003F_FFFC;
      logic [L-1:0] m = ($urandom_range(3) == 0) ? L'($urandom()) : '1;
      case (mode)
        0: fill(b, 1);
        1: fill(b, 2);
        2: fill(b, 8);
        3: fill(b, 32);
        default: for (int i = 0; i < L; i++) a[i] = {20'h0, $urandom_range(12'hFFF), 2'b00};
      endcase
      run(m, $urandom_range(60), "R7 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog R8 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule